// File: doc/BRIEF.md
# ACPI Power-State Sequencer Controller

This synchronous controller drives the enables of a combined memory-rail and standby-rail power chip through the ACPI sleep states. It reads logic flags only. Its inputs are an active-high enable (low means sleep), a sleep-state request, a suspend-to-disk status flag and digitized comparator results: VCC under-voltage, main 5 V good and memory rail stable. Its outputs are a soft-start hold command, the memory-rail and termination-rail enables, the standby LDO enable, two active-low switch drives (dual 5 V and USB 5 V) and a buffered sleep output.

After VCC recovers, the controller opens a start-up window with the standby LDO on and ignores all logic inputs. It then waits for main 5 V good and lets a fixed settle delay run before it releases soft-start on the memory rail. The termination rail comes up only once the memory rail reports stable. From then on the synchronized sleep request and suspend flag select one of three run-time output sets: working, suspend-to-RAM or soft-off with memory kept. A return to working is deferred until main 5 V is good.

Top module: `pwr_seq_top`

## Requirements
- R1: While `vccUv` is high at a clock edge, after that edge the outputs are ssHold=1, memEn=0, ttEn=0, sbyLdoEn=0, dualSwN=1, usbSwN=1, slpOut=0. When it is released, the start-up window begins at the next edge.
- R2: The start-up window lasts BOOT_CYC cycles. During it ssHold=1, sbyLdoEn=1, both rails are off and both switch drives are high. Toggling enable within the window does not change when the memory rail later turns on.
- R3: With enable high, memEn stays 0 while main5Ok is low. The edge that samples main5Ok high starts a SETTLE_CYC-cycle delay, and memEn rises with ssHold falling SETTLE_CYC edges later.
- R4: In soft-off (enable low), only the standby LDO is on: ssHold=1, memEn=ttEn=0, dualSwN=usbSwN=1, slpOut=0.
- R5: ttEn is high only while memEn is high. It rises only at an edge where memGood was sampled high, and it falls one edge after memGood is sampled low.
- R6: Sleep with suspend flag low gives dualSwN=0, usbSwN=1, slpOut=0, sbyLdoEn=1, and memory and termination rails on.
- R7: Sleep with suspend flag high gives dualSwN=0, usbSwN=0, slpOut=0, sbyLdoEn=1, and memory and termination rails on.
- R8: Working state (sleep request high) gives slpOut=1, dualSwN=1, usbSwN=1, sbyLdoEn=0, with the rails on.
- R9: A high sleep request does not enter the working state while main5Ok is low. The entry happens at the first edge that samples main5Ok high.
- R10: A sleep request falling in the working state changes the outputs at the third clock edge: two synchronizer stages plus the state register.
- R11: Enable going low after the start-up window forces soft-off from any state, and it takes effect at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vccUv | input | 1 | VCC under-voltage flag, synchronous |
| enIn | input | 1 | Enable, low requests soft-off (asynchronous) |
| slpReqIn | input | 1 | Sleep request, high means working (asynchronous) |
| suspIn | input | 1 | Suspend-to-disk status flag (asynchronous) |
| main5Ok | input | 1 | Main 5 V above threshold |
| memGood | input | 1 | Memory rail stable flag |
| ssHold | output | 1 | Soft-start discharge/hold command |
| memEn | output | 1 | Memory rail enable |
| ttEn | output | 1 | Termination rail enable |
| sbyLdoEn | output | 1 | Standby LDO enable |
| dualSwN | output | 1 | Dual-rail standby switch drive, active low |
| usbSwN | output | 1 | USB standby switch drive, active low |
| slpOut | output | 1 | Buffered sleep output, low while asleep |

## Verification
If the state register stopped in the wrong place, the error would reach the ports within the same cycle as a mismatched set of seven output levels. A counter limit that is off by one moves the rise of memEn by exactly one cycle from the computed edge. A stuck working/sleep flag shows after three edges, once a sleep request is toggled with main 5 V good. A stale termination flag shows one edge after memGood changes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_UV, ST_BOOT, ST_OFF, ST_WAIT5V, ST_SETTLE, ST_RUN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;     // count while high, clear while low
    logic useSettle;  // compare against settle limit instead of boot limit
  } seqStrobe_t;
endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int BOOT_CYC    = 2000,
  parameter int SETTLE_CYC  = 5000,
  parameter int SYNC_STAGES = 2,
  parameter int N_ASYNC     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [N_ASYNC-1:0] rawIn,
  output logic [N_ASYNC-1:0] syncOut,
  output logic               cntDone
);
  localparam int MAX_CYC = (BOOT_CYC > SETTLE_CYC) ? BOOT_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] BOOT_LIM   = CNT_W'(BOOT_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);

  // multi-stage synchronizer per asynchronous input
  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[SYNC_STAGES-1];
  end

  // shared window counter
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!strobe.cntRun) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign cntLim  = strobe.useSettle ? SETTLE_LIM : BOOT_LIM;
  assign cntDone = strobe.cntRun && (cnt == cntLim);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vccUv,
  input  logic       enS,
  input  logic       slpS,
  input  logic       suspS,
  input  logic       main5Ok,
  input  logic       memGood,
  input  logic       cntDone,
  output seqStrobe_t strobe,
  output logic       ssHold,
  output logic       memEn,
  output logic       ttEn,
  output logic       sbyLdoEn,
  output logic       dualSwN,
  output logic       usbSwN,
  output logic       slpOut
);
  seqState_t state, nextState;
  logic inS0;   // working state while running
  logic ttOn;   // termination rail granted

  always_comb begin
    nextState = state;
    unique case (state)
      ST_UV:     nextState = ST_BOOT;
      ST_BOOT:   if (cntDone) nextState = enS ? ST_WAIT5V : ST_OFF;
      ST_OFF:    if (enS) nextState = ST_WAIT5V;
      ST_WAIT5V: if (!enS) nextState = ST_OFF;
                 else if (main5Ok) nextState = ST_SETTLE;
      ST_SETTLE: if (!enS) nextState = ST_OFF;
                 else if (!main5Ok) nextState = ST_WAIT5V;
                 else if (cntDone) nextState = ST_RUN;
      ST_RUN:    if (!enS) nextState = ST_OFF;
      default:   nextState = ST_UV;
    endcase
    if (vccUv) nextState = ST_UV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_UV;
      inS0  <= 1'b0;
      ttOn  <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != ST_RUN)         inS0 <= 1'b0;
      else if (state != ST_RUN)        inS0 <= slpS && main5Ok;
      else if (inS0 && !slpS)          inS0 <= 1'b0;
      else if (!inS0 && slpS && main5Ok) inS0 <= 1'b1;
      ttOn <= (state == ST_RUN) && (nextState == ST_RUN) && memGood;
    end
  end

  assign strobe.cntRun    = (state == ST_BOOT) || (state == ST_SETTLE);
  assign strobe.useSettle = (state == ST_SETTLE);

  always_comb begin
    ssHold   = 1'b1;
    memEn    = 1'b0;
    ttEn     = 1'b0;
    sbyLdoEn = 1'b0;
    dualSwN  = 1'b1;
    usbSwN   = 1'b1;
    slpOut   = 1'b0;
    unique case (state)
      ST_BOOT, ST_OFF, ST_WAIT5V, ST_SETTLE: sbyLdoEn = 1'b1;
      ST_RUN: begin
        ssHold = 1'b0;
        memEn  = 1'b1;
        ttEn   = ttOn;
        if (inS0) begin
          slpOut = 1'b1;
        end else begin
          sbyLdoEn = 1'b1;
          dualSwN  = 1'b0;
          usbSwN   = !suspS;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int BOOT_CYC    = 2000,
  parameter int SETTLE_CYC  = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic vccUv,
  input  logic enIn,
  input  logic slpReqIn,
  input  logic suspIn,
  input  logic main5Ok,
  input  logic memGood,
  output logic ssHold,
  output logic memEn,
  output logic ttEn,
  output logic sbyLdoEn,
  output logic dualSwN,
  output logic usbSwN,
  output logic slpOut
);
  seqStrobe_t strobe;
  logic [2:0] syncBits;
  logic       cntDone;

  pwr_seq_dp #(
    .BOOT_CYC(BOOT_CYC), .SETTLE_CYC(SETTLE_CYC),
    .SYNC_STAGES(SYNC_STAGES), .N_ASYNC(3)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rawIn({suspIn, slpReqIn, enIn}),
    .syncOut(syncBits), .cntDone(cntDone)
  );

  pwr_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .vccUv(vccUv),
    .enS(syncBits[0]), .slpS(syncBits[1]), .suspS(syncBits[2]),
    .main5Ok(main5Ok), .memGood(memGood), .cntDone(cntDone),
    .strobe(strobe),
    .ssHold(ssHold), .memEn(memEn), .ttEn(ttEn), .sbyLdoEn(sbyLdoEn),
    .dualSwN(dualSwN), .usbSwN(usbSwN), .slpOut(slpOut)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rstN,
  input logic vccUv,
  input logic main5Ok,
  input logic memGood,
  input logic ssHold,
  input logic memEn,
  input logic ttEn,
  input logic sbyLdoEn,
  input logic dualSwN,
  input logic usbSwN,
  input logic slpOut
);
  // R1: under-voltage forces the safe output set
  p_uv_safe_r1: assert property (@(posedge clk) disable iff (!rstN)
    vccUv |=> (ssHold && !memEn && !ttEn && !sbyLdoEn));

  // R3: memory rail only turns on at an edge that saw main 5V good
  p_mem_needs_5v_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memEn) |-> $past(main5Ok));

  // R5: termination rail needs memory rail on
  p_tt_needs_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    ttEn |-> memEn);

  // R5: termination rail rises only after memGood was seen
  p_tt_after_good_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ttEn) |-> $past(memGood));

  // R8: working state releases LDO and switches
  p_s0_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    slpOut |-> (!sbyLdoEn && dualSwN && usbSwN && memEn));

  // R9: working state entered only with main 5V good
  p_s0_needs_5v_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slpOut) |-> $past(main5Ok));
endmodule

bind pwr_seq_top pwr_seq_chk i_chk (
  .clk(clk), .rstN(rstN), .vccUv(vccUv), .main5Ok(main5Ok),
  .memGood(memGood), .ssHold(ssHold), .memEn(memEn), .ttEn(ttEn),
  .sbyLdoEn(sbyLdoEn), .dualSwN(dualSwN), .usbSwN(usbSwN), .slpOut(slpOut)
);

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;
  localparam int BOOT   = 40;
  localparam int SETTLE = 25;
  // output vector order: {ssHold, memEn, ttEn, sbyLdoEn, dualSwN, usbSwN, slpOut}
  localparam logic [6:0] OUT_UV  = 7'b1000110;
  localparam logic [6:0] OUT_OFF = 7'b1001110;

  logic clk = 1'b0;
  logic rstN, vccUv, enIn, slpReqIn, suspIn, main5Ok, memGood;
  logic ssHold, memEn, ttEn, sbyLdoEn, dualSwN, usbSwN, slpOut;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  pwr_seq_top #(.BOOT_CYC(BOOT), .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) i_pwr_seq_top (
    .clk(clk), .rstN(rstN), .vccUv(vccUv), .enIn(enIn), .slpReqIn(slpReqIn),
    .suspIn(suspIn), .main5Ok(main5Ok), .memGood(memGood),
    .ssHold(ssHold), .memEn(memEn), .ttEn(ttEn), .sbyLdoEn(sbyLdoEn),
    .dualSwN(dualSwN), .usbSwN(usbSwN), .slpOut(slpOut)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] expRun(input logic s0, input logic susp, input logic tt);
    if (s0) return {1'b0, 1'b1, tt, 1'b0, 1'b1, 1'b1, 1'b1};
    return {1'b0, 1'b1, tt, 1'b1, 1'b0, ~susp, 1'b0};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] got;
    got = {ssHold, memEn, ttEn, sbyLdoEn, dualSwN, usbSwN, slpOut};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b at t=%0t", req, got, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        bad++;
        $display("FAIL watchdog: got=hang expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic expS0;
    void'($urandom(32'd4711));
    rstN = 0; vccUv = 1; enIn = 0; slpReqIn = 0; suspIn = 0; main5Ok = 0; memGood = 0;
    step(3);
    rstN = 1;
    step(2);
    check("R1 reset/uv", OUT_UV);

    enIn = 1; slpReqIn = 1; main5Ok = 1;
    step(4);
    check("R1 uv held", OUT_UV);
    vccUv = 0;
    // R2: enable toggled inside the window has no effect on timing
    step(5); enIn = 0;
    step(10); enIn = 1;
    step(BOOT - 15);
    check("R2 window end", OUT_OFF);
    step(SETTLE + 1);
    check("R2 R3 before rail on", OUT_OFF);
    step(1);
    check("R3 R8 rail on, working", expRun(1'b1, 1'b0, 1'b0));

    memGood = 1; step(1);
    check("R5 tt on", expRun(1'b1, 1'b0, 1'b1));
    memGood = 0; step(1);
    check("R5 tt off", expRun(1'b1, 1'b0, 1'b0));
    memGood = 1; step(1);

    slpReqIn = 0; step(2);
    check("R10 not yet", expRun(1'b1, 1'b0, 1'b1));
    step(1);
    check("R10 R6 sleep memory kept", expRun(1'b0, 1'b0, 1'b1));
    suspIn = 1; step(2);
    check("R7 suspend", expRun(1'b0, 1'b1, 1'b1));

    main5Ok = 0; slpReqIn = 1; step(6);
    check("R9 held asleep", expRun(1'b0, 1'b1, 1'b1));
    main5Ok = 1; step(1);
    check("R9 wake", expRun(1'b1, 1'b1, 1'b1));

    enIn = 0; step(2);
    check("R11 not yet", expRun(1'b1, 1'b1, 1'b1));
    step(1);
    check("R11 R4 soft-off", OUT_OFF);

    enIn = 1; step(3 + SETTLE);
    check("R3 settling", OUT_OFF);
    step(1);
    check("R3 R5 re-entry", expRun(1'b1, 1'b1, 1'b0));

    enIn = 0; step(3);
    check("R4 off", OUT_OFF);
    main5Ok = 0; enIn = 1; step(10);
    check("R3 waiting 5V", OUT_OFF);
    main5Ok = 1; step(SETTLE);
    check("R3 settle edge", OUT_OFF);
    step(1);
    check("R3 on after settle", expRun(1'b1, 1'b1, 1'b0));

    // random run-time phase
    expS0 = 1'b1;
    for (int i = 0; i < 300; i++) begin
      slpReqIn = 1'($urandom);
      suspIn   = 1'($urandom);
      main5Ok  = 1'($urandom);
      memGood  = 1'($urandom);
      step(6);
      expS0 = slpReqIn ? (main5Ok ? 1'b1 : expS0) : 1'b0;
      check("R5 R6 R7 R8 R9 random", expRun(expS0, suspIn, memGood));
    end

    vccUv = 1; step(1);
    check("R1 uv in run", OUT_UV);
    vccUv = 0; step(1);
    check("R1 R2 restart window", OUT_OFF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule